// File: doc/BRIEF.md
# Sign-Extending Ripple Adder with Widened Result

This block adds two binary operands whose widths may differ and returns a result one bit wider than the wider operand. Both operands are first brought to a common width N, the larger of the two input widths. The sum is then formed by a chain of one-bit adder cells, each passing its carry to the next. The block has no clock and no storage: the result follows the inputs combinationally.

The extra result bit is the point of the block. In two's-complement mode, the top bit is not the carry leaving the chain. It is the true sign of the exact sum, found as the XOR of the two extended operand sign bits and the final carry. Because of this, the N+1 bit result always holds the exact value and can never overflow. A parameter switches the block to unsigned use. In that mode the operands are zero-extended and the top bit is the plain carry-out.

A typical use is an accumulator front end or address calculation. Such a circuit can take the wide result as is, with no overflow logic after it.

Top module: `sx_ripple_add`

## Requirements
- R1: The common width N equals the larger of WA and WB. With SIGNED=1, the narrower operand is sign-extended to N bits, so a 4-bit operand 4'b1111 counts as -1.
- R2: With SIGNED=0, both operands are zero-extended to N bits, so a 4-bit operand 4'b1111 counts as 15.
- R3: With SIGNED=1, `sum` read as an (N+1)-bit two's-complement number equals the exact sum of the two operands read as signed numbers, for every operand pair, including the two most negative values.
- R4: With SIGNED=1, `sum[N]` is 1 exactly when the exact signed sum is negative. This holds even where an N-bit result would overflow.
- R5: With SIGNED=0, `sum` read as an unsigned number equals the exact unsigned sum, and `sum[N]` is the carry out of bit position N-1.
- R6: Bit 0 of `sum` is a[0] XOR b[0]. Position 0 has no carry-in.
- R7: With WA=WB=1, the block produces a correct 2-bit result in both modes. In signed mode, 1+1 gives -2 (2'b10).
- R8: The result depends only on the present inputs. A change of operands shows at `sum` without any clock edge, and every output bit is driven for every N of 1 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WA | First operand |
| b | input | WB | Second operand |
| sum | output | N+1 | Widened sum, where N = max(WA, WB) |

## Verification
The hardest case to reach is a signed sum where an N-bit adder would overflow. Here the raw carry and the sign bit of the sum disagree, so only the corrected top bit gives the right answer. This happens only when both operand sign bits match and the magnitudes are large, as in adding the two most negative values. The stimulus sweeps every pair for small unequal widths in both modes, so each such pair is applied. A long random run at wider widths then covers sign extension of the narrower operand across many values.

// File: rtl/sx_ripple_add.sv
module sx_ripple_add #(
  parameter int WA = 6,
  parameter int WB = 4,
  parameter bit SIGNED = 1'b1,
  localparam int N = (WA > WB) ? WA : WB
) (
  input  logic [WA-1:0] a,
  input  logic [WB-1:0] b,
  output logic [N:0]    sum
);

  logic [N-1:0] ae, be, cy;

  if (SIGNED) begin : g_sx
    assign ae = N'($signed(a));
    assign be = N'($signed(b));
  end else begin : g_zx
    assign ae = N'(a);
    assign be = N'(b);
  end

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i == 0) begin : g_half
      assign sum[0] = ae[0] ^ be[0];
      assign cy[0]  = ae[0] & be[0];
    end else begin : g_full
      logic p;
      assign p      = ae[i] ^ be[i];
      assign sum[i] = p ^ cy[i-1];
      assign cy[i]  = (ae[i] & be[i]) | (p & cy[i-1]);
    end
  end

  if (SIGNED) begin : g_top_s
    assign sum[N] = ae[N-1] ^ be[N-1] ^ cy[N-1];
  end else begin : g_top_u
    assign sum[N] = cy[N-1];
  end

endmodule

module sx_ripple_add_chk #(
  parameter int WA = 6,
  parameter int WB = 4,
  parameter bit SIGNED = 1'b1,
  localparam int N = (WA > WB) ? WA : WB
) (
  input logic [WA-1:0] a,
  input logic [WB-1:0] b,
  input logic [N:0]    sum
);

  logic [N:0] xa, xb, exact;

  if (SIGNED) begin : g_s
    assign xa = (N+1)'($signed(a));
    assign xb = (N+1)'($signed(b));
  end else begin : g_u
    assign xa = (N+1)'(a);
    assign xb = (N+1)'(b);
  end

  assign exact = xa + xb;

  always_comb begin
    if (!$isunknown({a, b})) begin
      assert_bit0_R6: assert (sum[0] == (a[0] ^ b[0]));
      if (SIGNED) begin
        assert_exact_signed_R3: assert (sum == exact);
        assert_no_overflow_R4: assert (sum[N] == ($signed(xa) + $signed(xb) < 0));
        if (a == '0) begin
          assert_sign_ext_R1: assert (sum == xb);
        end
      end else begin
        assert_exact_unsigned_R5: assert (sum == exact);
        if (a == '0) begin
          assert_zero_ext_R2: assert (sum[N] == 1'b0);
        end
      end
    end
  end

endmodule

bind sx_ripple_add sx_ripple_add_chk #(.WA(WA), .WB(WB), .SIGNED(SIGNED)) u_chk (
  .a(a), .b(b), .sum(sum)
);

// File: tb/sx_ripple_add_bench.sv
module sx_ripple_add_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  logic [5:0]  a6;  logic [3:0]  b4;  logic [6:0]  s7;
  logic [3:0]  ua;  logic [5:0]  ub;  logic [6:0]  us;
  logic [0:0]  sa1, sb1, ua1, ub1;
  logic [1:0]  ss2, us2;
  logic [15:0] wa;  logic [11:0] wb;  logic [16:0] ws;

  sx_ripple_add u_sx_ripple_add (.a(a6), .b(b4), .sum(s7));
  sx_ripple_add #(.WA(4), .WB(6), .SIGNED(1'b0)) u_uns (.a(ua), .b(ub), .sum(us));
  sx_ripple_add #(.WA(1), .WB(1), .SIGNED(1'b1)) u_one_s (.a(sa1), .b(sb1), .sum(ss2));
  sx_ripple_add #(.WA(1), .WB(1), .SIGNED(1'b0)) u_one_u (.a(ua1), .b(ub1), .sum(us2));
  sx_ripple_add #(.WA(16), .WB(12), .SIGNED(1'b1)) u_wide (.a(wa), .b(wb), .sum(ws));

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    a6 = '0; b4 = '0; ua = '0; ub = '0; sa1 = '0; sb1 = '0;
    ua1 = '0; ub1 = '0; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 zero operands", int'($signed(s7)), 0);
    check("R5 zero operands", int'(us), 0);

    // R8: output follows input between edges, no clock needed
    @(posedge clk); #1;
    a6 = 6'd5; b4 = 4'd2; #1;
    check("R8 comb response", int'($signed(s7)), 7);

    // R1: narrower operand 4'b1111 reads as -1
    a6 = 6'd0; b4 = 4'hF; @(negedge clk);
    check("R1 sign extension", int'($signed(s7)), -1);
    // R2: in unsigned mode 4'b1111 reads as 15
    ua = 4'hF; ub = 6'd0; @(negedge clk);
    check("R2 zero extension", int'(us), 15);

    // R4: overflow corner, two most negative values
    a6 = 6'b100000; b4 = 4'b1000; @(negedge clk);
    check("R4 most negative", int'($signed(s7)), -40);
    check("R4 sign bit", int'(s7[6]), 1);
    a6 = 6'b011111; b4 = 4'b0111; @(negedge clk);
    check("R4 most positive", int'(s7[6]), 0);

    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 16; j++) begin
        a6 = 6'(i); b4 = 4'(j);
        @(negedge clk);
        check("R3 signed sweep", int'($signed(s7)), int'($signed(a6)) + int'($signed(b4)));
        check("R4 top bit", int'(s7[6]), (int'($signed(a6)) + int'($signed(b4)) < 0) ? 1 : 0);
        check("R6 bit0", int'(s7[0]), int'(a6[0] ^ b4[0]));
      end
    end

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 64; j++) begin
        ua = 4'(i); ub = 6'(j);
        @(negedge clk);
        check("R5 unsigned sweep", int'(us), i + j);
        check("R5 carry bit", int'(us[6]), (i + j > 63) ? 1 : 0);
      end
    end

    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        sa1 = 1'(i); sb1 = 1'(j); ua1 = 1'(i); ub1 = 1'(j);
        @(negedge clk);
        check("R7 one-bit signed", int'($signed(ss2)), -i - j);
        check("R7 one-bit unsigned", int'(us2), i + j);
      end
    end

    for (int k = 0; k < 3000; k++) begin
      wa = 16'($urandom); wb = 12'($urandom);
      if (k == 0) begin wa = 16'h8000; wb = 12'h800; end
      if (k == 1) begin wa = 16'h7FFF; wb = 12'h7FF; end
      @(negedge clk);
      check("R3 wide random", int'($signed(ws)), int'($signed(wa)) + int'($signed(wb)));
      check("R1 wide extension", int'(ws[16]), (int'($signed(wa)) + int'($signed(wb)) < 0) ? 1 : 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule